// File: doc/BRIEF.md
# Page-Buffer Load and Timed Write Engine

This block gathers single-byte writes into a page buffer. It decides that loading has finished when the write stream has been quiet for a set number of microsecond ticks. It then runs a timed internal write cycle that hands the whole page to a storage array model. Nothing ends a page load explicitly. Every byte that arrives restarts the inactivity count, so loading may go on for as long as bytes keep coming in time. The low address bits choose the byte within the page. The upper address bits of the last byte loaded choose which page is committed. Any offset that was not loaded during the current page load is committed as FFh.

Byte writes arrive on a valid/ready stream. `wr_ready` is held high, so the engine never back-pressures the writer. While the engine is busy, a byte that is presented is consumed and dropped. The commit side is a valid/ready stream to the array. `cm_valid` and its address and data hold steady until `cm_ready` is seen. A full page of `PAGE_BYTES` entries goes out in ascending offset order, and the array may stall it at any time. After the last entry is accepted, the engine waits `WRITE_TIME_US` ticks before it lowers `busy`. While `busy` is high, reads return a status byte instead of the array data.

Top module: `pgw_engine`

## Requirements
- R1: When `rst_n` has been low, the following values hold: `busy`=0, `cm_valid`=0, `wr_ready`=1, and `rd_data` equals `arr_rdata`.
- R2: A byte accepted while idle or loading is stored at offset `wr_addr[6:0]`. If the same offset is loaded again before the commit, the later byte replaces the earlier one.
- R3: Every committed entry carries page address `cm_addr[15:7]` equal to `wr_addr[15:7]` of the last byte loaded.
- R4: Loading ends after `LOAD_TIMEOUT_US` `us_tick` pulses in which no byte is accepted. Each accepted byte restarts the count. A byte and a tick on the same cycle count as a byte. Loading continues for as long as the gaps stay shorter than this count.
- R5: A commit issues exactly `PAGE_BYTES` handshakes, with `cm_addr[6:0]` running from 0 to 127 in ascending order.
- R6: While `cm_valid` is high and `cm_ready` is low, the next cycle keeps `cm_valid` high and keeps `cm_addr` and `cm_data` unchanged.
- R7: `busy` rises on the cycle after loading ends. It stays high through the commit and through `WRITE_TIME_US` ticks after the last commit handshake, and then falls. `cm_valid` is never high while `busy` is low.
- R8: A byte presented while `busy` is high is accepted (`wr_ready`=1) and has no effect on any page that is committed later.
- R9: The loaded-offset record is cleared when a new page load begins. Offsets loaded in an earlier page that are not reloaded are committed as FFh.
- R10: While `busy` is high, `rd_data[7]` is the complement of bit 7 of the last loaded byte and `rd_data[5:0]` is 0. `rd_data[6]` starts at 0 in each write cycle and inverts after every `rd_strobe` cycle. While `busy` is low, `rd_data` equals `arr_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| wr_valid | input | 1 | Byte write presented |
| wr_ready | output | 1 | Byte write taken (always high) |
| wr_addr | input | 16 | Byte address: page in [15:7], offset in [6:0] |
| wr_data | input | 8 | Byte to load |
| cm_valid | output | 1 | Commit entry presented to the array |
| cm_ready | input | 1 | Array takes the commit entry |
| cm_addr | output | 16 | Commit address: page and offset |
| cm_data | output | 8 | Commit byte, FFh for unloaded offsets |
| busy | output | 1 | Internal write cycle in progress |
| rd_strobe | input | 1 | A read is performed this cycle |
| arr_rdata | input | 8 | Array read data for normal reads |
| rd_data | output | 8 | Read result: array data or write status |

## Verification
The assertions assume that `cm_ready` may toggle freely, that `rd_strobe` is a single-cycle event, and that `us_tick` is a pulse no wider than one cycle. The bench keeps to these: it asserts a pseudo-random `cm_ready` pattern on the commit stream, pulses `rd_strobe` for one cycle at a time, and raises `us_tick` on alternate cycles. This means the timeouts are counted in ticks rather than in clock cycles. The bench times its byte gaps to sit just under the load timeout, so the quiet-period restart is exercised at its margin. It also presents writes while `busy` is high, to show that those bytes are dropped.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
  typedef enum logic [1:0] {
    PG_IDLE   = 2'd0,
    PG_LOAD   = 2'd1,
    PG_COMMIT = 2'd2,
    PG_WAIT   = 2'd3
  } pg_state_e;

  function automatic int unsigned pg_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/pgw_page_buf.sv
module pgw_page_buf #(
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_mask,
  input  logic             wr_en,
  input  logic [OFF_W-1:0] wr_off,
  input  logic [7:0]       wr_byte,
  input  logic [OFF_W-1:0] rd_off,
  output logic [7:0]       rd_byte
);
  logic [7:0]            mem [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] loaded;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_off] <= wr_byte;
  end

  // one presence flag per offset; a new page load wipes all but the byte being written
  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_flag
    logic hit;
    logic flag_q;
    assign hit = wr_en && (wr_off == OFF_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)                flag_q <= 1'b0;
      else if (clr_mask || hit)  flag_q <= hit;
    end
    assign loaded[g] = flag_q;
  end

  assign rd_byte = loaded[rd_off] ? mem[rd_off] : 8'hFF;
endmodule

// File: rtl/pgw_tick_timer.sv
module pgw_tick_timer #(
  parameter int CNT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_val,
  output logic             fire
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (tick)   cnt_q <= cnt_q + 1'b1;
  end

  assign fire = tick && (cnt_q == last_val);
endmodule

// File: rtl/pgw_status.sv
module pgw_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       rd_strobe,
  input  logic       last_msb,
  input  logic [7:0] arr_rdata,
  output logic [7:0] rd_data
);
  logic tog_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     tog_q <= 1'b0;
    else if (busy)  tog_q <= tog_q ^ rd_strobe;
    else            tog_q <= 1'b0;
  end

  assign rd_data = busy ? {~last_msb, tog_q, 6'd0} : arr_rdata;
endmodule

// File: rtl/pgw_engine.sv
module pgw_engine #(
  parameter int ADDR_W          = 16,
  parameter int PAGE_BYTES      = 128,
  parameter int LOAD_TIMEOUT_US = 200,
  parameter int WRITE_TIME_US   = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              us_tick,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              cm_valid,
  input  logic              cm_ready,
  output logic [ADDR_W-1:0] cm_addr,
  output logic [7:0]        cm_data,
  output logic              busy,
  input  logic              rd_strobe,
  input  logic [7:0]        arr_rdata,
  output logic [7:0]        rd_data
);
  import pgw_pkg::*;

  localparam int OFF_W   = $clog2(PAGE_BYTES);
  localparam int PAGE_W  = ADDR_W - OFF_W;
  localparam int CNT_MAX = pg_max(LOAD_TIMEOUT_US, WRITE_TIME_US);
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] LOAD_LAST  = CNT_W'(LOAD_TIMEOUT_US - 1);
  localparam logic [CNT_W-1:0] WRITE_LAST = CNT_W'(WRITE_TIME_US - 1);
  localparam logic [OFF_W-1:0] OFF_END    = OFF_W'(PAGE_BYTES - 1);

  pg_state_e         state_q, state_d;
  logic [OFF_W-1:0]  idx_q;
  logic [PAGE_W-1:0] page_q;
  logic [7:0]        last_q;
  logic              accept;
  logic              tmr_clr;
  logic              tmr_fire;
  logic [CNT_W-1:0]  tmr_last;

  assign wr_ready = 1'b1;
  assign accept   = wr_valid && ((state_q == PG_IDLE) || (state_q == PG_LOAD));
  assign busy     = (state_q == PG_COMMIT) || (state_q == PG_WAIT);
  assign cm_valid = (state_q == PG_COMMIT);
  assign cm_addr  = {page_q, idx_q};

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PG_IDLE:   if (accept) state_d = PG_LOAD;
      PG_LOAD:   if (!accept && tmr_fire) state_d = PG_COMMIT;
      PG_COMMIT: if (cm_ready && (idx_q == OFF_END)) state_d = PG_WAIT;
      PG_WAIT:   if (tmr_fire) state_d = PG_IDLE;
      default:   state_d = PG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= PG_IDLE;
      idx_q   <= '0;
      page_q  <= '0;
      last_q  <= 8'd0;
    end else begin
      state_q <= state_d;
      if (state_q != PG_COMMIT) idx_q <= '0;
      else if (cm_ready)        idx_q <= idx_q + 1'b1;
      if (accept) begin
        page_q <= wr_addr[ADDR_W-1:OFF_W];
        last_q <= wr_data;
      end
    end
  end

  assign tmr_last = (state_q == PG_WAIT) ? WRITE_LAST : LOAD_LAST;
  assign tmr_clr  = accept || tmr_fire || (state_q == PG_IDLE) || (state_q == PG_COMMIT);

  pgw_tick_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (tmr_clr),
    .tick     (us_tick),
    .last_val (tmr_last),
    .fire     (tmr_fire)
  );

  pgw_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_mask (accept && (state_q == PG_IDLE)),
    .wr_en    (accept),
    .wr_off   (wr_addr[OFF_W-1:0]),
    .wr_byte  (wr_data),
    .rd_off   (idx_q),
    .rd_byte  (cm_data)
  );

  pgw_status u_status (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .rd_strobe (rd_strobe),
    .last_msb  (last_q[7]),
    .arr_rdata (arr_rdata),
    .rd_data   (rd_data)
  );
endmodule

// File: rtl/pgw_engine_chk.sv
module pgw_engine_chk #(
  parameter int ADDR_W     = 16,
  parameter int PAGE_BYTES = 128,
  localparam int OFF_W = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic              cm_valid,
  input logic              cm_ready,
  input logic [ADDR_W-1:0] cm_addr,
  input logic [7:0]        cm_data,
  input logic              busy,
  input logic              rd_strobe,
  input logic [7:0]        rd_data
);
  localparam logic [OFF_W-1:0] OFF_END = OFF_W'(PAGE_BYTES - 1);

  p_commit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && !cm_ready |=> cm_valid && $stable(cm_addr) && $stable(cm_data));

  p_commit_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_ready && (cm_addr[OFF_W-1:0] != OFF_END)
    |=> cm_valid && (cm_addr[OFF_W-1:0] == $past(cm_addr[OFF_W-1:0]) + 1'b1));

  p_page_fixed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid && cm_ready && (cm_addr[OFF_W-1:0] != OFF_END)
    |=> cm_addr[ADDR_W-1:OFF_W] == $past(cm_addr[ADDR_W-1:OFF_W]));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !cm_valid);

  p_quiet_before_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(wr_valid));

  p_toggle_flip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && $past(rd_strobe) |-> rd_data[6] != $past(rd_data[6]));

  p_toggle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) && !$past(rd_strobe) |-> $stable(rd_data[6]));
endmodule

bind pgw_engine pgw_engine_chk #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_valid  (wr_valid),
  .cm_valid  (cm_valid),
  .cm_ready  (cm_ready),
  .cm_addr   (cm_addr),
  .cm_data   (cm_data),
  .busy      (busy),
  .rd_strobe (rd_strobe),
  .rd_data   (rd_data)
);

// File: tb/pgw_engine_bench.sv
module pgw_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 16;
  localparam int PAGE_BYTES = 128;
  localparam int LOAD_TO    = 200;
  localparam int WRITE_T    = 5000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              us_tick = 1'b0;
  logic              wr_valid = 1'b0;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [7:0]        wr_data = 8'd0;
  logic              cm_valid;
  logic              cm_ready = 1'b0;
  logic [ADDR_W-1:0] cm_addr;
  logic [7:0]        cm_data;
  logic              busy;
  logic              rd_strobe = 1'b0;
  logic [7:0]        arr_rdata = 8'd0;
  logic [7:0]        rd_data;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgw_engine #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
               .LOAD_TIMEOUT_US(LOAD_TO), .WRITE_TIME_US(WRITE_T)) u_pgw_engine (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .cm_valid(cm_valid), .cm_ready(cm_ready), .cm_addr(cm_addr), .cm_data(cm_data),
    .busy(busy), .rd_strobe(rd_strobe), .arr_rdata(arr_rdata), .rd_data(rd_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // background stimulus, moved 1 time unit after each rising edge
  logic [7:0] lfsr = 8'hA7;
  always @(posedge clk) begin
    #1;
    us_tick   = ~us_tick;
    lfsr      = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    cm_ready  = lfsr[0] | lfsr[2];
    arr_rdata = arr_rdata + 8'd3;
  end

  // behavioural reference: 0 idle, 1 loading, 2 committing, 3 write wait
  int       m_state, m_tmr, m_idx, m_page;
  bit [7:0] m_buf [PAGE_BYTES];
  bit       m_have [PAGE_BYTES];
  bit [7:0] m_last;
  bit       m_tog;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_tmr = 0; m_idx = 0; m_page = 0; m_last = 0; m_tog = 0;
      foreach (m_have[i]) m_have[i] = 0;
    end else begin
      if (m_state >= 2) m_tog = m_tog ^ rd_strobe; else m_tog = 0;
      case (m_state)
        0: if (wr_valid) begin
             foreach (m_have[i]) m_have[i] = 0;
             m_buf[wr_addr[6:0]] = wr_data; m_have[wr_addr[6:0]] = 1;
             m_page = wr_addr[15:7]; m_last = wr_data; m_tmr = 0; m_state = 1;
           end
        1: if (wr_valid) begin
             m_buf[wr_addr[6:0]] = wr_data; m_have[wr_addr[6:0]] = 1;
             m_page = wr_addr[15:7]; m_last = wr_data; m_tmr = 0;
           end else if (us_tick) begin
             if (m_tmr == LOAD_TO - 1) begin m_state = 2; m_idx = 0; m_tmr = 0; end
             else m_tmr++;
           end
        2: if (cm_ready) begin
             if (m_idx == PAGE_BYTES - 1) begin m_state = 3; m_tmr = 0; end
             else m_idx++;
           end
        default: if (us_tick) begin
             if (m_tmr == WRITE_T - 1) m_state = 0; else m_tmr++;
           end
      endcase
    end
  end

  // per-cycle comparison and commit capture, away from the clock edge
  bit [7:0] cap [PAGE_BYTES];
  int       cap_page, cap_cnt;
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit [7:0] exp_rd;
      exp_rd = (m_state >= 2) ? {~m_last[7], m_tog, 6'd0} : arr_rdata;
      check(busy == (m_state >= 2), "R7 busy", busy, m_state >= 2);
      check(cm_valid == (m_state == 2), "R5 cm_valid", cm_valid, m_state == 2);
      check(wr_ready == 1'b1, "R8 wr_ready", wr_ready, 1);
      check(rd_data == exp_rd, "R10 rd_data", rd_data, exp_rd);
      if (m_state == 2) begin
        check(cm_addr == ADDR_W'({m_page[8:0], m_idx[6:0]}), "R3 cm_addr", cm_addr,
              {m_page[8:0], m_idx[6:0]});
        check(cm_data == (m_have[m_idx] ? m_buf[m_idx] : 8'hFF), "R2 cm_data", cm_data,
              m_have[m_idx] ? m_buf[m_idx] : 8'hFF);
      end
      if (cm_valid && cm_ready) begin
        cap[cm_addr[6:0]] = cm_data;
        cap_page = cm_addr[15:7];
        cap_cnt++;
      end
    end
  end

  // intent of each page, kept apart from the model
  bit [7:0] exp_pg [PAGE_BYTES];
  int       exp_page;

  task automatic new_page();
    foreach (exp_pg[i]) exp_pg[i] = 8'hFF;
    cap_cnt = 0;
  endtask

  task automatic put(input int page, input int off, input bit [7:0] d, input bit keep);
    @(posedge clk); #2;
    wr_valid = 1'b1; wr_addr = ADDR_W'((page << 7) | off); wr_data = d;
    @(posedge clk); #2;
    wr_valid = 1'b0;
    if (keep) begin exp_pg[off] = d; exp_page = page; end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic wait_busy(input bit v, input string req);
    int k = 0;
    @(negedge clk);
    while (busy != v && k < 20000) begin @(negedge clk); k++; end
    check(busy == v, req, busy, v);
  endtask

  task automatic read_pulse();
    @(posedge clk); #2; rd_strobe = 1'b1;
    @(posedge clk); #2; rd_strobe = 1'b0;
    @(negedge clk);
  endtask

  task automatic check_page(input string tag);
    int bad = 0;
    check(cap_cnt == PAGE_BYTES, {"R5 commit count ", tag}, cap_cnt, PAGE_BYTES);
    check(cap_page == exp_page, {"R3 commit page ", tag}, cap_page, exp_page);
    foreach (exp_pg[i]) if (cap[i] != exp_pg[i]) begin
      bad++;
      $display("FAIL R9 %s offset %0d actual=%0h expected=%0h", tag, i, cap[i], exp_pg[i]);
    end
    check(bad == 0, {"R2 page contents ", tag}, bad, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      done = 1'b1;
      check(1'b0, "watchdog", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cycles(5);
    @(negedge clk);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(cm_valid == 1'b0, "R1 cm_valid in reset", cm_valid, 0);
    check(wr_ready == 1'b1, "R1 wr_ready in reset", wr_ready, 1);
    check(rd_data == arr_rdata, "R1 rd_data in reset", rd_data, arr_rdata);
    @(posedge clk); #2; rst_n = 1'b1;

    // page 1: scattered offsets with an overwrite of offset 1
    new_page();
    put(5, 0, 8'hA5, 1);
    put(5, 1, 8'h3C, 1);
    put(5, 127, 8'h7E, 1);
    put(5, 1, 8'hC3, 1);
    wait_busy(1'b1, "R4 load timeout page 1");
    check(rd_data[7] == 1'b0, "R10 poll bit page 1", rd_data[7], 0);
    check(rd_data[6] == 1'b0, "R10 toggle start", rd_data[6], 0);
    check(rd_data[5:0] == 6'd0, "R10 low bits", rd_data[5:0], 0);
    read_pulse();
    check(rd_data[6] == 1'b1, "R10 toggle first read", rd_data[6], 1);
    read_pulse();
    check(rd_data[6] == 1'b0, "R10 toggle second read", rd_data[6], 0);
    wait_busy(1'b0, "R7 write end page 1");
    check(rd_data == arr_rdata, "R10 normal read after write", rd_data, arr_rdata);
    check_page("page 1");

    // page 2: gaps just under the timeout, page changes with the last byte
    new_page();
    put(9'h0A3, 3, 8'h12, 1);
    wait_cycles(2 * (LOAD_TO - 10));
    @(negedge clk);
    check(busy == 1'b0, "R4 still loading after gap 1", busy, 0);
    put(9'h0A3, 70, 8'h34, 1);
    wait_cycles(2 * (LOAD_TO - 10));
    @(negedge clk);
    check(busy == 1'b0, "R4 still loading after gap 2", busy, 0);
    put(9'h1FF, 4, 8'h56, 1);
    wait_busy(1'b1, "R4 load timeout page 2");
    check(rd_data[7] == 1'b1, "R10 poll bit page 2", rd_data[7], 1);
    put(9'h1FF, 50, 8'h11, 0);
    put(9'h002, 9, 8'h22, 0);
    wait_busy(1'b0, "R7 write end page 2");
    check_page("page 2");

    // page 3: only one byte; earlier bytes and busy-time bytes must read FFh
    new_page();
    put(9'h002, 9, 8'h99, 1);
    wait_busy(1'b1, "R4 load timeout page 3");
    wait_busy(1'b0, "R7 write end page 3");
    check(cap[50] == 8'hFF, "R8 busy-time byte dropped", cap[50], 8'hFF);
    check(cap[3] == 8'hFF, "R9 old offset cleared", cap[3], 8'hFF);
    check_page("page 3");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule